// File: doc/BRIEF.md
# UART Modem Control and Status Register Block

This block is the modem-facing register slice of a UART. A CPU writes a control register whose bits drive three active-low handshake/user pins: request-to-send and two general-purpose outputs. A loop-back mode bit forces all three pins to their inactive high level. An automatic flow-control bit lets the receiver's threshold signal pull request-to-send inactive without software involvement.

On the status side, the ring-indicator line is brought into the clock domain through a two-flop synchronizer. Its present level is visible in the status register. A sticky flag records each low-to-high transition. When the modem-status interrupt is enabled at the moment of a transition, an interrupt request is raised. Reading the status register clears both the flag and the request, unless another rising transition is detected in the same cycle.

Register map (2-bit address): 0 = control (read/write, 8 bits), 1 = status (read, clear-on-read with the read strobe), 2 = interrupt enable (bit 0 = modem-status enable), 3 = reads zero. The read data is a combinational function of the address. Only the read strobe causes side effects.

Top module: `mcsTop`

## Requirements
- R1: After master reset (rst high), the control and enable registers read zero, rtsN, out1N and out2N are high, status bit 2 is 0 and msIrq is 0.
- R2: With loop mode off, out1N is low exactly when control bit 2 is set, and out2N is low exactly when control bit 3 is set.
- R3: With loop mode off and no auto-RTS override, rtsN is low exactly when control bit 1 is set.
- R4: While control bit 4 (loop mode) is set, rtsN, out1N and out2N are all high, whatever the other control bits hold.
- R5: While control bit 5 (auto-RTS) is set and rxThresh is high, rtsN is high. rxThresh has no effect on rtsN when bit 5 is clear.
- R6: Status bit 6 shows the ring-indicator level delayed by the two synchronizer stages. It follows a change of ringIn after the second rising clock edge.
- R7: Status bit 2 becomes 1 one cycle after a synchronized low-to-high transition of ringIn. A high-to-low transition does not set it.
- R8: A status read (rdEn with address 1) clears status bit 2 and msIrq at the next edge. If a rising transition is detected in the same cycle, the bit stays set.
- R9: msIrq rises together with status bit 2 only if enable bit 0 (address 2) is set when the transition is detected. A transition while disabled leaves msIrq low.
- R10: A value written to address 0 is returned unchanged by a read of address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Master reset, active high, synchronous |
| wrEn | input | 1 | CPU write strobe |
| rdEn | input | 1 | CPU read strobe (side effects only) |
| addr | input | 2 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the addressed register |
| ringIn | input | 1 | Asynchronous ring-indicator level |
| rxThresh | input | 1 | Receiver threshold reached, from receive logic |
| rtsN | output | 1 | Request-to-send pin, active low |
| out1N | output | 1 | User output 1, active low |
| out2N | output | 1 | User output 2, active low |
| msIrq | output | 1 | Modem-status interrupt request |

## Verification
The hardest case to reach is a status read that lands in the same cycle as a newly detected rising ring transition. The flag must survive that read. The ring edge only appears two synchronizer edges after the pin moves, so the bench counts clock edges from the pin change. It asserts the read strobe exactly in the cycle where the synchronized level is high and the delayed copy is still low. Auto-RTS and loop mode are swept against every control pattern in a vector table, so the precedence between the overrides and the register bits is observed at the pins.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_IEN  = 2'd2;

  localparam int CTRL_RTS  = 1;
  localparam int CTRL_OUT1 = 2;
  localparam int CTRL_OUT2 = 3;
  localparam int CTRL_LOOP = 4;
  localparam int CTRL_AUTO = 5;

  localparam int STAT_RFLAG = 2;
  localparam int STAT_RLVL  = 6;

  localparam int IEN_MS = 0;

  typedef struct packed {
    logic wrCtrl;
    logic wrIen;
    logic rdStat;
  } mcsStrobe_t;
endpackage

// File: rtl/mcsCtrl.sv
module mcsCtrl
  import mcs_pkg::*;
(
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output mcsStrobe_t        strobe
);
  always_comb begin
    strobe        = '0;
    strobe.wrCtrl = wrEn && (addr == ADDR_CTRL);
    strobe.wrIen  = wrEn && (addr == ADDR_IEN);
    strobe.rdStat = rdEn && (addr == ADDR_STAT);
  end
endmodule

// File: rtl/mcsDatapath.sv
module mcsDatapath
  import mcs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  mcsStrobe_t        strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              ringIn,
  input  logic              rxThresh,
  output logic              rtsN,
  output logic              out1N,
  output logic              out2N,
  output logic              msIrq,
  output logic [DATA_W-1:0] ctrlQ,
  output logic              ringSync,
  output logic              ringFlag
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [DATA_W-1:0]  ienQ;
  logic [LAST:0]      syncQ;
  logic               ringDly;
  logic               ringRise;
  logic               irqQ;
  logic               loopOn;
  logic               autoHold;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlQ <= '0;
      ienQ  <= '0;
    end else begin
      if (strobe.wrCtrl) ctrlQ <= wrData;
      if (strobe.wrIen)  ienQ  <= wrData;
    end
  end

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (rst) syncQ <= '0;
        else     syncQ <= ringIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (rst) syncQ <= '0;
        else     syncQ <= {syncQ[LAST-1:0], ringIn};
      end
    end
  endgenerate

  assign ringSync = syncQ[LAST];
  assign ringRise = ringSync && !ringDly;

  always_ff @(posedge clk) begin
    if (rst) begin
      ringDly  <= 1'b0;
      ringFlag <= 1'b0;
      irqQ     <= 1'b0;
    end else begin
      ringDly <= ringSync;
      if (ringRise) begin
        ringFlag <= 1'b1;
        if (ienQ[IEN_MS]) irqQ <= 1'b1;
      end else if (strobe.rdStat) begin
        ringFlag <= 1'b0;
        irqQ     <= 1'b0;
      end
    end
  end

  assign msIrq    = irqQ;
  assign loopOn   = ctrlQ[CTRL_LOOP];
  assign autoHold = ctrlQ[CTRL_AUTO] && rxThresh;

  assign rtsN  = !(ctrlQ[CTRL_RTS]  && !loopOn && !autoHold);
  assign out1N = !(ctrlQ[CTRL_OUT1] && !loopOn);
  assign out2N = !(ctrlQ[CTRL_OUT2] && !loopOn);

  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_CTRL: rdData = ctrlQ;
      ADDR_STAT: begin
        rdData[STAT_RFLAG] = ringFlag;
        rdData[STAT_RLVL]  = ringSync;
      end
      ADDR_IEN:  rdData = ienQ;
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/mcsTop.sv
module mcsTop
  import mcs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              ringIn,
  input  logic              rxThresh,
  output logic              rtsN,
  output logic              out1N,
  output logic              out2N,
  output logic              msIrq
);
  mcsStrobe_t        strobe;
  logic [DATA_W-1:0] ctrlQ;
  logic              ringSync;
  logic              ringFlag;

  mcsCtrl ctrl_i (
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .addr   (addr),
    .strobe (strobe)
  );

  mcsDatapath #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .addr     (addr),
    .wrData   (wrData),
    .rdData   (rdData),
    .ringIn   (ringIn),
    .rxThresh (rxThresh),
    .rtsN     (rtsN),
    .out1N    (out1N),
    .out2N    (out2N),
    .msIrq    (msIrq),
    .ctrlQ    (ctrlQ),
    .ringSync (ringSync),
    .ringFlag (ringFlag)
  );
endmodule

// File: rtl/mcsChecker.sv
module mcsChecker
  import mcs_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic              rxThresh,
  input logic              rtsN,
  input logic              out1N,
  input logic              out2N,
  input logic              msIrq,
  input logic [DATA_W-1:0] ctrlQ,
  input logic              ringSync,
  input logic              ringFlag
);
  AST_LOOP_PINS_HIGH: assert property (@(posedge clk) disable iff (rst)
    ctrlQ[CTRL_LOOP] |-> (rtsN && out1N && out2N)); // R4

  AST_AUTO_RTS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ctrlQ[CTRL_AUTO] && rxThresh) |-> rtsN); // R5

  AST_FLAG_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(ringSync) |=> ringFlag); // R7

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rdEn && addr == ADDR_STAT && !$rose(ringSync)) |=> (!ringFlag && !msIrq)); // R8

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    msIrq |-> ringFlag); // R9

  AST_RESET_PINS: assert property (@(posedge clk)
    $past(rst) |-> (rtsN && out1N && out2N && !msIrq)); // R1
endmodule

bind mcsTop mcsChecker chk_i (
  .clk      (clk),
  .rst      (rst),
  .rdEn     (rdEn),
  .addr     (addr),
  .rxThresh (rxThresh),
  .rtsN     (rtsN),
  .out1N    (out1N),
  .out2N    (out2N),
  .msIrq    (msIrq),
  .ctrlQ    (ctrlQ),
  .ringSync (ringSync),
  .ringFlag (ringFlag)
);

// File: tb/mcsTop_tb_top.sv
module mcsTop_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic       ringIn = 1'b0;
  logic       rxThresh = 1'b0;
  logic       rtsN, out1N, out2N, msIrq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  mcsTop dut_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .ringIn(ringIn), .rxThresh(rxThresh),
    .rtsN(rtsN), .out1N(out1N), .out2N(out2N), .msIrq(msIrq)
  );

  // {ctrl[7:0], rxThresh, expRtsN, expOut1N, expOut2N}
  localparam logic [11:0] VEC [10] = '{
    12'h007, 12'h023, 12'h045, 12'h086, 12'h0E0,
    12'h1E7, 12'h2EC, 12'h2E0, 12'h0E8, 12'h3EF
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic statRead();
    @(negedge clk);
    rdEn = 1'b1; addr = 2'd1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  initial begin
    #40000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    peek(2'd0, rd); check("R1 ctrl", rd, 8'h00);
    peek(2'd2, rd); check("R1 ien", rd, 8'h00);
    peek(2'd1, rd); check("R1 status flag", {7'd0, rd[2]}, 8'd0);
    check("R1 pins", {5'd0, rtsN, out1N, out2N}, 8'h07);
    check("R1 irq", {7'd0, msIrq}, 8'd0);

    // vector table: R2 R3 R4 R5
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      rxThresh = VEC[i][3];
      regWrite(2'd0, VEC[i][11:4]);
      #1;
      check("R3 R4 R5 rtsN",  {7'd0, rtsN},  {7'd0, VEC[i][2]});
      check("R2 R4 out1N",    {7'd0, out1N}, {7'd0, VEC[i][1]});
      check("R2 R4 out2N",    {7'd0, out2N}, {7'd0, VEC[i][0]});
    end
    rxThresh = 1'b0;

    // R10 readback
    regWrite(2'd0, 8'hA9);
    peek(2'd0, rd); check("R10 ctrl readback", rd, 8'hA9);
    regWrite(2'd0, 8'h00);

    // R6 level latency, R7 rise sets flag, R9 disabled gives no irq
    @(negedge clk); ringIn = 1'b1;
    @(negedge clk);
    peek(2'd1, rd); check("R6 level after one edge", {7'd0, rd[6]}, 8'd0);
    @(negedge clk);
    peek(2'd1, rd); check("R6 level after two edges", {7'd0, rd[6]}, 8'd1);
    @(negedge clk);
    peek(2'd1, rd); check("R7 flag on rise", {7'd0, rd[2]}, 8'd1);
    check("R9 no irq while disabled", {7'd0, msIrq}, 8'd0);

    // R8 read clears
    statRead();
    peek(2'd1, rd); check("R8 flag cleared", {7'd0, rd[2]}, 8'd0);

    // R7 falling edge does not set
    @(negedge clk); ringIn = 1'b0;
    repeat (3) @(negedge clk);
    peek(2'd1, rd); check("R7 no flag on fall", {7'd0, rd[2]}, 8'd0);
    check("R6 level low", {7'd0, rd[6]}, 8'd0);

    // R9 enabled irq, R8 read clears irq
    regWrite(2'd2, 8'h01);
    @(negedge clk); ringIn = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 irq on enabled rise", {7'd0, msIrq}, 8'd1);
    statRead();
    check("R8 irq cleared by read", {7'd0, msIrq}, 8'd0);

    // R8 collision: read in the cycle the rise is detected
    @(negedge clk); ringIn = 1'b0;
    repeat (3) @(negedge clk);
    ringIn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rdEn = 1'b1; addr = 2'd1;
    @(negedge clk);
    rdEn = 1'b0;
    peek(2'd1, rd); check("R8 flag kept on collision", {7'd0, rd[2]}, 8'd1);
    check("R8 irq kept on collision", {7'd0, msIrq}, 8'd1);
    statRead();
    peek(2'd1, rd); check("R8 flag cleared after", {7'd0, rd[2]}, 8'd0);

    // R1 reset again restores pins
    regWrite(2'd0, 8'h0E);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    #1;
    check("R1 pins after reset", {5'd0, rtsN, out1N, out2N}, 8'h07);
    peek(2'd0, rd); check("R1 ctrl after reset", rd, 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule